// File: doc/BRIEF.md
# Receive Frame Padding Inserter

This block sits in the receive data path between a MAC and its DMA engine. It works on a byte-wide valid/ready stream that carries an end-of-frame flag. In every frame it can splice a run of zero-valued filler bytes at a chosen byte offset, so that the payload fields that follow line up on a convenient boundary in memory. The filler count ranges from 0 to 31 and the offset from 0 to 65535.

A 32-bit control word holds the filler count and the offset. Software can write this word at any time. A write changes only the held copy. The engine keeps using its active settings until a synchronous software reset pulse copies the held copy into them. The same pulse also discards any frame progress. Apart from the filler run, bytes flow straight through, and backpressure from the consumer reaches the producer with no loss and no duplication.

Top module: `rx_pad_inserter`

## Requirements
- R1: The control word keeps the filler count in bits 20..16 and the insertion offset in bits 15..0. Bits 31..21 always read as zero, whatever was written to them. A write shows on `cfg_rdata` from the cycle after the write.
- R2: After `rst_n` both fields are zero, `cfg_rdata` reads zero, `out_valid` is low while no input is offered, and frames pass through unchanged.
- R3: A write does not change the stream until `sw_rst` is pulsed. Frames sent after a write and before the pulse use the old settings. Frames sent after the pulse use the written values.
- R4: A filler count of zero passes every frame through unchanged.
- R5: With offset N and count S, a frame that has more than N bytes comes out as its first N bytes, then S filler bytes, then the rest of its bytes in order. Offset 0 puts the filler ahead of the first byte.
- R6: Filler bytes have the value 0x00 and never carry the end-of-frame flag. The flag stays on the last real byte of the frame.
- R7: The byte position restarts at zero in each new frame. Filler is inserted at most once per frame.
- R8: A frame whose length is less than or equal to the offset is passed through unchanged. This includes the case where the length equals the offset.
- R9: While filler bytes are being sent, `in_ready` is low. When `out_ready` is low, the offered output byte stays stable, and no input byte is lost or duplicated.
- R10: While `sw_rst` is high, `in_ready` and `out_valid` are low. After the pulse, the next byte counts as position zero of a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous software reset; applies held settings and clears frame progress |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data (held copy) |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte ends the frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte ends the frame |

## Verification
The checker watches several rules on every cycle:
- control readback after each write, with reserved bits cleared;
- active settings changing only on a software reset pulse;
- zero-valued filler that never carries the end-of-frame flag, with input held off while filler goes out;
- stable output under stall;
- an accepted input byte appearing unchanged on the output in the same cycle;
- both handshakes quiet during the reset pulse.

Only the bench scenarios can show that the whole frame order is right. That covers the exact position and length of the filler run, a single insertion per frame, frames no longer than the offset, and the counter restarting after a software reset that cuts a frame short. The bench shows this by comparing every output byte against a scoreboard queue under random stalls and sizes.

// File: rtl/rx_pad_pkg.sv
package rx_pad_pkg;

    typedef enum logic {
        ST_PASS = 1'b0,
        ST_FILL = 1'b1
    } pad_state_e;

    localparam logic [7:0] FILL_BYTE = 8'h00;

endpackage

// File: rtl/rx_pad_cfg.sv
module rx_pad_cfg #(
    parameter int REG_W  = 32,
    parameter int SIZE_W = 5,
    parameter int SLOT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [SIZE_W-1:0] act_size,
    output logic [SLOT_W-1:0] act_slot
);
    localparam int FIELD_W  = SIZE_W + SLOT_W;
    localparam int SIZE_LSB = SLOT_W;

    typedef struct packed {
        logic [SIZE_W-1:0] held_size;
        logic [SLOT_W-1:0] held_slot;
        logic [SIZE_W-1:0] run_size;
        logic [SLOT_W-1:0] run_slot;
    } cfg_regs_t;

    cfg_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            regs_d.held_size = wdata[SIZE_LSB +: SIZE_W];
            regs_d.held_slot = wdata[0 +: SLOT_W];
        end
        if (sw_rst) begin
            regs_d.run_size = regs_q.held_size;
            regs_d.run_slot = regs_q.held_slot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    generate
        if (REG_W > FIELD_W) begin : g_rsvd
            assign rdata = {{(REG_W-FIELD_W){1'b0}}, regs_q.held_size, regs_q.held_slot};
        end else begin : g_full
            assign rdata = {regs_q.held_size, regs_q.held_slot};
        end
    endgenerate

    assign act_size = regs_q.run_size;
    assign act_slot = regs_q.run_slot;

endmodule

// File: rtl/rx_pad_ctrl.sv
module rx_pad_ctrl
    import rx_pad_pkg::*;
#(
    parameter int SIZE_W = 5,
    parameter int SLOT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic [SIZE_W-1:0] act_size,
    input  logic [SLOT_W-1:0] act_slot,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic              fill_sel
);
    localparam int CNT_W = SLOT_W + 1;

    typedef struct packed {
        pad_state_e        state;
        logic [CNT_W-1:0]  pos;
        logic [SIZE_W-1:0] left;
        logic              done;
    } ctrl_regs_t;

    ctrl_regs_t regs_d, regs_q;

    logic              at_slot;
    logic              start_fill;
    logic              in_xfer;
    logic [SIZE_W-1:0] left_after;

    always_comb begin
        at_slot    = (regs_q.pos == CNT_W'(act_slot));
        start_fill = (regs_q.state == ST_PASS) && in_valid && !regs_q.done
                     && (act_size != '0) && at_slot;
        fill_sel   = (regs_q.state == ST_FILL) || start_fill;
        out_valid  = !sw_rst && (fill_sel || in_valid);
        in_ready   = !sw_rst && !fill_sel && out_ready;
        in_xfer    = in_valid && in_ready;
        left_after = act_size - SIZE_W'(out_ready);

        regs_d = regs_q;
        if (sw_rst) begin
            regs_d.state = ST_PASS;
            regs_d.pos   = '0;
            regs_d.left  = '0;
            regs_d.done  = 1'b0;
        end else if (start_fill) begin
            if (left_after == '0) begin
                regs_d.state = ST_PASS;
                regs_d.done  = 1'b1;
            end else begin
                regs_d.state = ST_FILL;
                regs_d.left  = left_after;
            end
        end else if (regs_q.state == ST_FILL) begin
            if (out_ready) begin
                regs_d.left = regs_q.left - 1'b1;
                if (regs_q.left == SIZE_W'(1)) begin
                    regs_d.state = ST_PASS;
                    regs_d.done  = 1'b1;
                end
            end
        end else if (in_xfer) begin
            if (in_last) begin
                regs_d.pos  = '0;
                regs_d.done = 1'b0;
            end else if (regs_q.pos != '1) begin
                regs_d.pos = regs_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_PASS, pos: '0, left: '0, done: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/rx_pad_mux.sv
module rx_pad_mux
    import rx_pad_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              fill_sel,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    always_comb begin
        if (fill_sel) begin
            out_data = DATA_W'(FILL_BYTE);
            out_last = 1'b0;
        end else begin
            out_data = in_data;
            out_last = in_last;
        end
    end

endmodule

// File: rtl/rx_pad_inserter.sv
module rx_pad_inserter #(
    parameter int REG_W  = 32,
    parameter int SIZE_W = 5,
    parameter int SLOT_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              cfg_wr_en,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    logic [SIZE_W-1:0] act_size;
    logic [SLOT_W-1:0] act_slot;
    logic              fill_sel;

    rx_pad_cfg #(.REG_W(REG_W), .SIZE_W(SIZE_W), .SLOT_W(SLOT_W)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_rst   (sw_rst),
        .wr_en    (cfg_wr_en),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .act_size (act_size),
        .act_slot (act_slot)
    );

    rx_pad_ctrl #(.SIZE_W(SIZE_W), .SLOT_W(SLOT_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst    (sw_rst),
        .act_size  (act_size),
        .act_slot  (act_slot),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .fill_sel  (fill_sel)
    );

    rx_pad_mux #(.DATA_W(DATA_W)) mux_i (
        .fill_sel (fill_sel),
        .in_data  (in_data),
        .in_last  (in_last),
        .out_data (out_data),
        .out_last (out_last)
    );

endmodule

// File: rtl/rx_pad_checker.sv
module rx_pad_checker #(
    parameter int REG_W  = 32,
    parameter int SIZE_W = 5,
    parameter int SLOT_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_rst,
    input logic              cfg_wr_en,
    input logic [REG_W-1:0]  cfg_wdata,
    input logic [REG_W-1:0]  cfg_rdata,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              in_last,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last,
    input logic              fill_sel,
    input logic [SIZE_W-1:0] act_size,
    input logic [SLOT_W-1:0] act_slot
);
    localparam int FIELD_W = SIZE_W + SLOT_W;
    localparam logic [REG_W-1:0] FIELD_MASK = REG_W'({FIELD_W{1'b1}});

    AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> cfg_rdata == ($past(cfg_wdata) & FIELD_MASK)); // R1

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $rose(rst_n) |-> (cfg_rdata == '0) && (act_size == '0) && (act_slot == '0)); // R2

    AST_CFG_ONLY_ON_SWRST: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rst |=> $stable(act_size) && $stable(act_slot)); // R3

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> out_valid && (out_data == in_data) && (out_last == in_last)); // R5

    AST_FILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_sel && out_valid) |-> (out_data == '0) && !out_last); // R6

    AST_FILL_HOLDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        fill_sel |-> !in_ready); // R9

    AST_OUT_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last)); // R9

    AST_SWRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |-> !in_ready && !out_valid); // R10

endmodule

bind rx_pad_inserter rx_pad_checker #(
    .REG_W(REG_W), .SIZE_W(SIZE_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_rst    (sw_rst),
    .cfg_wr_en (cfg_wr_en),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .fill_sel  (fill_sel),
    .act_size  (act_size),
    .act_slot  (act_slot)
);

// File: tb/rx_pad_inserter_tb_top.sv
module rx_pad_inserter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        out_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_pad_inserter dut_i (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    logic [8:0] exp_q[$];
    string      cur_req = "R2";
    int         n_cmp = 0;
    int         n_bad = 0;
    int         stall_pct = 0;
    int         m_size = 0, m_slot = 0, m_cnt = 0;
    bit         m_done = 1'b0;
    int         h_size = 0, h_slot = 0;
    bit         finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // output consumer: random backpressure, changed away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            out_ready = ($urandom_range(0, 99) >= stall_pct);
        end
    end

    // monitor: pops the scoreboard on every output transfer
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, "unexpected output byte", {23'd0, out_last, out_data}, 32'h0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check({out_last, out_data} == e, cur_req, "output byte",
                      {23'd0, out_last, out_data}, {23'd0, e});
            end
        end
    end

    task automatic send_byte(input logic [7:0] d, input bit last, input int gap);
        bit acc;
        if (!m_done && m_size != 0 && m_cnt == m_slot) begin
            repeat (m_size) exp_q.push_back(9'h000);
            m_done = 1'b1;
        end
        exp_q.push_back({last, d});
        if (last) begin
            m_cnt = 0;
            m_done = 1'b0;
        end else begin
            m_cnt++;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_data  = d;
        in_last  = last;
        do begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #1;
        end while (!acc);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (gap) @(posedge clk);
    endtask

    task automatic send_frame(input int len, input logic [7:0] seed, input bit gaps);
        for (int i = 0; i < len; i++) begin
            send_byte(seed + 8'(i), i == len - 1, gaps ? $urandom_range(0, 1) : 0);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        check(exp_q.size() == 0, cur_req, "scoreboard drained", exp_q.size(), 0);
    endtask

    task automatic cfg_write(input logic [31:0] w);
        @(posedge clk);
        #1;
        cfg_wr_en = 1'b1;
        cfg_wdata = w;
        h_size = int'(w[20:16]);
        h_slot = int'(w[15:0]);
        @(posedge clk);
        #1;
        cfg_wr_en = 1'b0;
        @(negedge clk);
        check(cfg_rdata == (w & 32'h001F_FFFF), "R1", "control readback", cfg_rdata, w & 32'h001F_FFFF);
    endtask

    task automatic soft_reset(input bit offer);
        @(posedge clk);
        #1;
        sw_rst = 1'b1;
        if (offer) begin
            in_valid = 1'b1;
            in_data  = 8'hA5;
        end
        @(negedge clk);
        check(!in_ready && !out_valid, "R10", "handshakes during sw_rst",
              {30'd0, in_ready, out_valid}, 32'h0);
        @(posedge clk);
        #1;
        sw_rst = 1'b0;
        in_valid = 1'b0;
        m_size = h_size;
        m_slot = h_slot;
        m_cnt  = 0;
        m_done = 1'b0;
    endtask

    task automatic apply(input int size, input int slot);
        cfg_write({11'd0, 5'(size), 16'(slot)});
        soft_reset(1'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL %s watchdog expired: actual 0x%0h expected 0x%0h", cur_req, 1, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check(cfg_rdata == 32'h0, "R2", "control word after reset", cfg_rdata, 32'h0);
        check(!out_valid, "R2", "out_valid idle after reset", {31'd0, out_valid}, 32'h0);

        cur_req = "R2";
        send_frame(6, 8'h10, 1'b0);
        drain();

        // R1/R3: write without applying; reserved bits dropped
        cur_req = "R3";
        cfg_write(32'hFFE5_0003);
        send_frame(8, 8'h20, 1'b0);
        drain();
        soft_reset(1'b0);
        cur_req = "R5";
        send_frame(8, 8'h30, 1'b0);
        drain();

        // R5: offset 0, max filler
        apply(31, 0);
        send_frame(4, 8'h40, 1'b1);
        drain();

        // R4: zero count
        cur_req = "R4";
        apply(0, 2);
        send_frame(7, 8'h50, 1'b0);
        drain();

        // R8: length equals offset, shorter than offset, far offset
        cur_req = "R8";
        apply(3, 5);
        send_frame(5, 8'h60, 1'b0);
        send_frame(2, 8'h68, 1'b0);
        drain();
        apply(7, 16'hFFFF);
        send_frame(9, 8'h70, 1'b0);
        drain();

        // R5/R6: offset = length-1, count 1
        cur_req = "R6";
        apply(1, 4);
        send_frame(5, 8'h80, 1'b0);
        drain();

        // R7: back-to-back frames, one insertion each
        cur_req = "R7";
        apply(2, 1);
        send_frame(6, 8'h90, 1'b0);
        send_frame(3, 8'h98, 1'b0);
        send_frame(1, 8'h9C, 1'b0);
        drain();

        // R9: heavy backpressure during filler
        cur_req = "R9";
        stall_pct = 70;
        apply(9, 2);
        send_frame(10, 8'hA0, 1'b1);
        send_frame(10, 8'hB0, 1'b0);
        drain();
        stall_pct = 0;

        // R10: sw_rst mid-frame restarts the position count
        cur_req = "R10";
        apply(2, 3);
        send_byte(8'hC0, 1'b0, 0);
        send_byte(8'hC1, 1'b0, 0);
        drain();
        soft_reset(1'b1);
        send_frame(5, 8'hC8, 1'b0);
        drain();

        // R5: random sizes, offsets, lengths and stalls
        cur_req = "R5";
        for (int k = 0; k < 25; k++) begin
            stall_pct = $urandom_range(0, 60);
            apply($urandom_range(0, 31), $urandom_range(0, 20));
            send_frame($urandom_range(1, 24), 8'($urandom_range(0, 255)), 1'b1);
            send_frame($urandom_range(1, 24), 8'($urandom_range(0, 255)), 1'b0);
            drain();
        end
        stall_pct = 0;

        finish_run();
    end

endmodule